// File: doc/BRIEF.md
# Tagged Cache-Line Refill Memory Responder

This block is the memory endpoint behind a processor tile. It holds data as whole cache lines, each line made of a fixed number of word-sized beats. A requester sends commands on one channel (a store flag, a line address and a tag) and store data on a second channel, one word per beat. Answers come back on a third channel that carries valid, tag and data and has no ready input.

A load command turns into a burst of response beats, one per word of the line. They leave in ascending word order and every beat carries the tag of the load. A store command opens a store window. The next data beats fill the addressed line word by word, and the window then closes. While the window is open no command is taken, and while it is closed no data is taken. The response queue drains one beat per cycle. A new command is held off whenever the queue could not take one more full line.

Top module: `refill_responder`

## Requirements
- R1: `cmdReady` is 1 only when no store window is open and the response queue has room for one more line. `dataReady` is 1 only while a store window is open. A command offered while `cmdReady` is 0 has no effect, so no response appears.
- R2: A command handshake and a data handshake never complete in the same cycle.
- R3: The first word of a line sits at word address line × BEATS, and beat b uses word address line × BEATS + b. Data stored to a line is returned by a later load of that line, beat for beat, and leaves other lines unchanged.
- R4: An accepted store command opens the store window. From the next cycle, `dataReady` is 1 and `cmdReady` is 0.
- R5: Accepted data beats are counted modulo BEATS. After the BEATS-th beat the window closes: in the next cycle `dataReady` is 0 and `cmdReady` is 1. Before that beat, `dataReady` stays 1.
- R6: An accepted load queues BEATS response beats in ascending word order, all carrying the load's tag. When the queue was empty, beat 0 appears in the cycle after acceptance.
- R7: `respValid` is 1 whenever the queue holds a beat. The head beat leaves on every cycle that `respValid` is 1, with no backpressure. Loads accepted back to back give a gap-free stream.
- R8: While `respValid` is 0, `respTag` and `respData` are both zero.
- R9: In one clock edge, the head pop happens before a new line is pushed. A load accepted while beats are draining lands behind them in the queue and does not overwrite them.
- R10: With the default depth of 8 and 4 beats per line, two loads accepted back to back drop `cmdReady` to 0. It returns to 1 only once the queue holds 4 beats or fewer.
- R11: Reset closes any store window, clears the beat counter and empties the queue. After reset, a store writes from beat 0 of its line.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be accepted |
| cmdStore | input | 1 | 1 = store command, 0 = load command |
| cmdLine | input | LINE_W | Line address |
| cmdTag | input | TAG_W | Tag returned with load beats |
| dataValid | input | 1 | Store data beat offered |
| dataReady | output | 1 | Store data beat can be accepted |
| dataIn | input | WORD_W | Store data word |
| respValid | output | 1 | Response beat present (no ready) |
| respTag | output | TAG_W | Tag of response beat, zero when idle |
| respData | output | WORD_W | Data of response beat, zero when idle |

## Verification
Lines are written and then read back with all-zero, all-one, alternating and counting word patterns. These tell apart a wrong word order inside a line, a wrong line stride, and one line overwriting another. The first and last lines of the array are both covered. Two loads issued back to back test that the output stream has no gaps, that the queue keeps its order across a pop and a push in the same edge, and that `cmdReady` drops and comes back at the right time. Further directed runs offer commands during a store window, and reset the block in the middle of a store and in the middle of a burst. These runs show that the block ignores commands it has not accepted, and that the beat counter starts again at zero after reset.

// File: rtl/refill_pkg.sv
package refill_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic popHead;    // drop the queue head this edge
    logic writeBeat;  // write dataIn to the open line
    logic latchBase;  // capture line base for a store
    logic pushLine;   // enqueue a whole line for a load
  } refillStrobe_t;

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic              cmdStore,
  input  logic              dataValid,
  input  logic              queueBusy,
  input  logic              lineRoom,
  output logic              cmdReady,
  output logic              dataReady,
  output logic [BEAT_W-1:0] beatIdx,
  output refillStrobe_t     strobe
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              storeOpen;
  logic [BEAT_W-1:0] beatCnt;
  logic              cmdFire;
  logic              dataFire;

  assign cmdReady  = !storeOpen && lineRoom;
  assign dataReady = storeOpen;
  assign cmdFire   = cmdValid && cmdReady;
  assign dataFire  = dataValid && dataReady;
  assign beatIdx   = beatCnt;

  always_comb begin
    strobe           = '0;
    strobe.popHead   = queueBusy;
    strobe.writeBeat = dataFire;
    strobe.latchBase = cmdFire && cmdStore;
    strobe.pushLine  = cmdFire && !cmdStore;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      storeOpen <= 1'b0;
      beatCnt   <= '0;
    end else begin
      if (dataFire) begin
        if (beatCnt == LAST_BEAT) begin
          beatCnt   <= '0;
          storeOpen <= 1'b0;
        end else begin
          beatCnt <= beatCnt + 1'b1;
        end
      end
      if (strobe.latchBase) begin
        storeOpen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 8,
  parameter int LINE_W    = 4,
  parameter int BEATS     = 4,
  parameter int MEM_LINES = 12,
  parameter int QDEPTH    = 8,
  parameter int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  refillStrobe_t     strobe,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic [LINE_W-1:0] cmdLine,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [WORD_W-1:0] dataIn,
  output logic              queueBusy,
  output logic              lineRoom,
  output logic [TAG_W-1:0]  headTag,
  output logic [WORD_W-1:0] headData
);

  localparam int MEM_WORDS = MEM_LINES * BEATS;
  localparam int WADDR_W   = $clog2(MEM_WORDS);
  localparam int WIDE_W    = LINE_W + BEAT_W + 1;
  localparam int PTR_W     = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W     = $clog2(QDEPTH + 1);
  localparam int ROOM_MAX  = QDEPTH - BEATS;

  // ---------------- line storage ----------------
  logic [WORD_W-1:0] memArr [MEM_WORDS];
  logic [WIDE_W-1:0] cmdBase;
  logic [WIDE_W-1:0] storeBase;
  logic [WIDE_W-1:0] writeAddr;

  assign cmdBase   = WIDE_W'(cmdLine) * WIDE_W'(BEATS);
  assign writeAddr = storeBase + WIDE_W'(beatIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      storeBase <= '0;
    end else if (strobe.latchBase) begin
      storeBase <= cmdBase;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeBeat && (writeAddr < WIDE_W'(MEM_WORDS))) begin
      memArr[writeAddr[WADDR_W-1:0]] <= dataIn;
    end
  end

  logic [WORD_W-1:0] lineWord [BEATS];

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    logic [WIDE_W-1:0] rdAddr;
    assign rdAddr      = cmdBase + WIDE_W'(b);
    assign lineWord[b] = (rdAddr < WIDE_W'(MEM_WORDS)) ?
                         memArr[rdAddr[WADDR_W-1:0]] : '0;
  end

  // ---------------- response queue ----------------
  logic [TAG_W-1:0]  qTag  [QDEPTH];
  logic [WORD_W-1:0] qData [QDEPTH];
  logic [PTR_W-1:0]  headPtr;
  logic [PTR_W-1:0]  tailPtr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] ptrAdvance(input logic [PTR_W-1:0] p,
                                                  input int step);
    int sum;
    sum = int'(p) + step;
    if (sum >= QDEPTH) sum = sum - QDEPTH;
    return PTR_W'(sum);
  endfunction

  assign queueBusy = (fill != '0);
  assign lineRoom  = (fill <= CNT_W'(ROOM_MAX));
  assign headTag   = queueBusy ? qTag[headPtr]  : '0;
  assign headData  = queueBusy ? qData[headPtr] : '0;

  always_ff @(posedge clk) begin
    if (strobe.pushLine) begin
      for (int b = 0; b < BEATS; b++) begin
        qTag[ptrAdvance(tailPtr, b)]  <= cmdTag;
        qData[ptrAdvance(tailPtr, b)] <= lineWord[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
    end else begin
      if (strobe.popHead) begin
        headPtr <= ptrAdvance(headPtr, 1);
      end
      if (strobe.pushLine) begin
        tailPtr <= ptrAdvance(tailPtr, BEATS);
      end
      fill <= fill - CNT_W'(strobe.popHead)
                   + (strobe.pushLine ? CNT_W'(BEATS) : '0);
    end
  end

endmodule

// File: rtl/refill_responder.sv
module refill_responder
  import refill_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 8,
  parameter int LINE_W    = 4,
  parameter int BEATS     = 4,
  parameter int MEM_LINES = 12,
  parameter int QDEPTH    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdStore,
  input  logic [LINE_W-1:0] cmdLine,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic [WORD_W-1:0] dataIn,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic [WORD_W-1:0] respData
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  refillStrobe_t     strobe;
  logic [BEAT_W-1:0] beatIdx;
  logic              queueBusy;
  logic              lineRoom;

  refill_ctrl #(
    .BEATS (BEATS),
    .BEAT_W(BEAT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdStore (cmdStore),
    .dataValid(dataValid),
    .queueBusy(queueBusy),
    .lineRoom (lineRoom),
    .cmdReady (cmdReady),
    .dataReady(dataReady),
    .beatIdx  (beatIdx),
    .strobe   (strobe)
  );

  refill_datapath #(
    .WORD_W   (WORD_W),
    .TAG_W    (TAG_W),
    .LINE_W   (LINE_W),
    .BEATS    (BEATS),
    .MEM_LINES(MEM_LINES),
    .QDEPTH   (QDEPTH),
    .BEAT_W   (BEAT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .beatIdx  (beatIdx),
    .cmdLine  (cmdLine),
    .cmdTag   (cmdTag),
    .dataIn   (dataIn),
    .queueBusy(queueBusy),
    .lineRoom (lineRoom),
    .headTag  (respTag),
    .headData (respData)
  );

  assign respValid = queueBusy;

endmodule

// File: rtl/refill_responder_chk.sv
module refill_responder_chk #(
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 8,
  parameter int LINE_W    = 4,
  parameter int BEATS     = 4,
  parameter int MEM_LINES = 12,
  parameter int QDEPTH    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              cmdStore,
  input logic [LINE_W-1:0] cmdLine,
  input logic [TAG_W-1:0]  cmdTag,
  input logic              dataValid,
  input logic              dataReady,
  input logic [WORD_W-1:0] dataIn,
  input logic              respValid,
  input logic [TAG_W-1:0]  respTag,
  input logic [WORD_W-1:0] respData
);

  localparam int CNT_W = $clog2(QDEPTH + BEATS + 1);

  logic cmdFire;
  logic dataFire;
  int   beatSeen;
  logic [CNT_W-1:0] occ;

  assign cmdFire  = cmdValid && cmdReady;
  assign dataFire = dataValid && dataReady;

  // independent count of accepted store beats and queued response beats
  always_ff @(posedge clk) begin
    if (rst) begin
      beatSeen <= 0;
      occ      <= '0;
    end else begin
      if (dataFire) beatSeen <= (beatSeen == BEATS - 1) ? 0 : beatSeen + 1;
      occ <= occ - CNT_W'(respValid) + ((cmdFire && !cmdStore) ? CNT_W'(BEATS) : '0);
    end
  end

  a_r2_no_dual_fire: assert property (@(posedge clk) disable iff (rst)
    !(cmdFire && dataFire));

  a_r4_store_opens: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && cmdStore) |=> (dataReady && !cmdReady));

  a_r5_last_beat_closes: assert property (@(posedge clk) disable iff (rst)
    (dataFire && beatSeen == BEATS - 1) |=> !dataReady);

  a_r5_mid_beat_holds: assert property (@(posedge clk) disable iff (rst)
    (dataFire && beatSeen != BEATS - 1) |=> dataReady);

  a_r6_first_beat_tag: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && !cmdStore && !respValid) |=> (respValid && respTag == $past(cmdTag)));

  a_r7_valid_tracks_fill: assert property (@(posedge clk) disable iff (rst)
    respValid == (occ != '0));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !respValid |-> (respTag == '0 && respData == '0));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(QDEPTH));

  a_r3_line_in_range: assert property (@(posedge clk) disable iff (rst)
    cmdFire |-> (int'(cmdLine) < MEM_LINES));

endmodule

bind refill_responder refill_responder_chk #(
  .WORD_W   (WORD_W),
  .TAG_W    (TAG_W),
  .LINE_W   (LINE_W),
  .BEATS    (BEATS),
  .MEM_LINES(MEM_LINES),
  .QDEPTH   (QDEPTH)
) u_chk (.*);

// File: tb/tb_refill_responder.sv
`timescale 1ns/1ps
module tb_refill_responder;

  localparam int WORD_W = 32, TAG_W = 8, LINE_W = 4, BEATS = 4, MEM_LINES = 12, QDEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0, cmdStore = 1'b0, dataValid = 1'b0;
  logic [LINE_W-1:0] cmdLine = '0;
  logic [TAG_W-1:0]  cmdTag = '0;
  logic [WORD_W-1:0] dataIn = '0;
  logic cmdReady, dataReady, respValid;
  logic [TAG_W-1:0]  respTag;
  logic [WORD_W-1:0] respData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refill_responder #(
    .WORD_W(WORD_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
    .BEATS(BEATS), .MEM_LINES(MEM_LINES), .QDEPTH(QDEPTH)
  ) dut (
    .clk(clk), .rst(rst),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdStore(cmdStore),
    .cmdLine(cmdLine), .cmdTag(cmdTag),
    .dataValid(dataValid), .dataReady(dataReady), .dataIn(dataIn),
    .respValid(respValid), .respTag(respTag), .respData(respData)
  );

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [TAG_W-1:0]  tag;
    logic [WORD_W-1:0] seed;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{line: 4'd0,  tag: 8'h11, seed: 32'h0000_0000},
    '{line: 4'd11, tag: 8'hFF, seed: 32'hFFFF_FFFF},
    '{line: 4'd5,  tag: 8'h00, seed: 32'hA5A5_A5A5},
    '{line: 4'd6,  tag: 8'h3C, seed: 32'h5A5A_5A5A},
    '{line: 4'd1,  tag: 8'h80, seed: 32'h1234_5678}
  };

  function automatic logic [WORD_W-1:0] wordOf(input logic [WORD_W-1:0] seed, input int b);
    return seed ^ {4{8'(b + 1)}};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic [LINE_W-1:0] line, input logic [WORD_W-1:0] seed);
    chk("R1 cmdReady before store", 64'(cmdReady), 64'd1);
    cmdValid = 1'b1; cmdStore = 1'b1; cmdLine = line;
    step();
    chk("R4 dataReady after store cmd", 64'(dataReady), 64'd1);
    chk("R1 cmdReady during store", 64'(cmdReady), 64'd0);
    // a load offered during the window must be ignored
    cmdStore = 1'b0; cmdTag = 8'h77;
    for (int i = 0; i < BEATS; i++) begin
      dataValid = 1'b1; dataIn = wordOf(seed, i);
      step();
      if (i < BEATS - 1) begin
        chk("R5 dataReady mid line", 64'(dataReady), 64'd1);
      end else begin
        chk("R5 dataReady after last beat", 64'(dataReady), 64'd0);
        chk("R5 cmdReady after last beat", 64'(cmdReady), 64'd1);
      end
    end
    cmdValid = 1'b0; dataValid = 1'b0;
    chk("R1 ignored command gave no response", 64'(respValid), 64'd0);
  endtask

  task automatic doLoad(input logic [LINE_W-1:0] line, input logic [TAG_W-1:0] tag,
                        input logic [WORD_W-1:0] seed);
    cmdValid = 1'b1; cmdStore = 1'b0; cmdLine = line; cmdTag = tag;
    step();
    cmdValid = 1'b0;
    for (int i = 0; i < BEATS; i++) begin
      chk("R6 respValid during burst", 64'(respValid), 64'd1);
      chk("R6 respTag", 64'(respTag), 64'(tag));
      chk("R3 respData word order", 64'(respData), 64'(wordOf(seed, i)));
      step();
    end
    chk("R8 respValid idle", 64'(respValid), 64'd0);
    chk("R8 respTag idle", 64'(respTag), 64'd0);
    chk("R8 respData idle", 64'(respData), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R11 reset state
    chk("R11 cmdReady after reset", 64'(cmdReady), 64'd1);
    chk("R11 dataReady after reset", 64'(dataReady), 64'd0);
    chk("R11 respValid after reset", 64'(respValid), 64'd0);
    chk("R8 respTag after reset", 64'(respTag), 64'd0);
    rst = 1'b0;
    step();

    // table: store every line, then read every line back (R3)
    for (int v = 0; v < NVEC; v++) doStore(VECS[v].line, VECS[v].seed);
    for (int v = 0; v < NVEC; v++) doLoad(VECS[v].line, VECS[v].tag, VECS[v].seed);

    // back-to-back loads: R7, R9, R10
    cmdValid = 1'b1; cmdStore = 1'b0; cmdLine = 4'd0; cmdTag = 8'h21;
    step();
    chk("R10 cmdReady with one line queued", 64'(cmdReady), 64'd1);
    chk("R6 first beat tag A", 64'(respTag), 64'h21);
    chk("R6 first beat data A", 64'(respData), 64'(wordOf(32'h0, 0)));
    cmdLine = 4'd11; cmdTag = 8'h22;
    step();
    cmdValid = 1'b0;
    for (int j = 0; j < 2 * BEATS - 1; j++) begin
      int k;
      k = j + 1;
      chk("R7 gap-free stream", 64'(respValid), 64'd1);
      if (k < BEATS) begin
        chk("R9 tag A kept", 64'(respTag), 64'h21);
        chk("R9 data A kept", 64'(respData), 64'(wordOf(32'h0, k)));
      end else begin
        chk("R9 tag B behind A", 64'(respTag), 64'h22);
        chk("R9 data B behind A", 64'(respData), 64'(wordOf(32'hFFFF_FFFF, k - BEATS)));
      end
      chk("R10 cmdReady vs queue room", 64'(cmdReady), 64'(j >= 3));
      step();
    end
    chk("R8 idle after stream", 64'(respValid), 64'd0);

    // reset in the middle of a burst
    cmdValid = 1'b1; cmdLine = 4'd6; cmdTag = 8'h3C;
    step();
    cmdValid = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R11 queue emptied by reset", 64'(respValid), 64'd0);

    // reset in the middle of a store, then a clean store must start at beat 0
    cmdValid = 1'b1; cmdStore = 1'b1; cmdLine = 4'd5;
    step();
    cmdValid = 1'b0; cmdStore = 1'b0;
    for (int i = 0; i < 2; i++) begin
      dataValid = 1'b1; dataIn = 32'hDEAD_0000 + 32'(i);
      step();
    end
    dataValid = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R11 store window closed by reset", 64'(dataReady), 64'd0);
    chk("R11 cmdReady after mid-store reset", 64'(cmdReady), 64'd1);
    doStore(4'd5, 32'hC3C3_C3C3);
    doLoad(4'd5, 8'h5E, 32'hC3C3_C3C3);
    doLoad(4'd6, 8'h66, 32'h5A5A_5A5A);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule